// File: doc/BRIEF.md
# Cartridge Bank Address Translator

This block sits between a console's CPU and PPU buses and the cartridge memories. Four 5-bit configuration registers (control, two CHR bank selectors and one PRG bank selector) are loaded in parallel, each by its own strobe. From them it computes the physical PRG ROM address for every CPU access in the upper 32 KB, the physical CHR address for every PPU pattern access, a write permit for the PRG RAM window and a 2-bit nametable mirroring code.

The control register picks one of three PRG layouts: whole 32 KB switching, a pinned first 16 KB bank with a switched upper window, or a switched lower window with the last bank pinned. It also picks between one 8 KB CHR bank and two independent 4 KB banks. Every address is recomputed combinationally from the current register contents, so a change of layout takes effect on the very next access with no rewrite of the bank registers.

The serial loader that assembles register values and the memory arrays themselves sit outside the block.

Top module: `bank_xlate_top`

## Requirements
- R1: After reset, control holds 0x0F (mirroring code 3, last-bank-pinned PRG layout, 8 KB CHR layout) and the three bank registers hold 0.
- R2: The `mirror` output equals control bits 1:0 (0 single-screen low, 1 single-screen high, 2 vertical, 3 horizontal) starting the cycle after a control load.
- R3: With control bit 4 at 0, the CHR bank is CHR-bank-0 bits 4:1 followed by PPU address bit 12; CHR bank 1 has no effect.
- R4: With control bit 4 at 1, PPU address bit 12 at 0 uses CHR bank 0 and at 1 uses CHR bank 1, each as a full 5-bit 4 KB bank number.
- R5: With control bits 3:2 equal to 0 or 1, the PRG 16 KB bank is PRG-bank bits 3:1 followed by CPU address bit 14; PRG-bank bit 0 has no effect.
- R6: With control bits 3:2 equal to 2, CPU address bit 14 at 0 maps bank 0 and at 1 maps PRG-bank bits 3:0.
- R7: With control bits 3:2 equal to 3, CPU address bit 14 at 0 maps PRG-bank bits 3:0 and at 1 maps bank PRG_BANKS-1.
- R8: `prg_ram_wen` is high only when `cpu_wr` is high, the address lies in 0x6000-0x7FFF and PRG-bank bit 4 is 0; bit 4 does not change the ROM bank.
- R9: `prg_ram_sel` is high exactly for CPU addresses 0x6000-0x7FFF and `prg_rom_sel` exactly for 0x8000-0xFFFF.
- R10: A changed control layout changes the PRG and CHR translation immediately with the bank registers untouched; a register strobed in one cycle is visible in the next.
- R11: Bank numbers wrap modulo PRG_BANKS (16 KB units) and CHR_BANKS (4 KB units); the low 14 (PRG) or 12 (CHR) address bits pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_ld | input | 1 | Load strobe for the control register |
| chr0_ld | input | 1 | Load strobe for CHR bank 0 |
| chr1_ld | input | 1 | Load strobe for CHR bank 1 |
| prg_ld | input | 1 | Load strobe for the PRG bank register |
| reg_wdata | input | 5 | Value written by any strobe |
| cpu_addr | input | 16 | CPU bus address |
| cpu_wr | input | 1 | CPU write cycle |
| ppu_addr | input | 13 | PPU pattern address |
| prg_rom_addr | output | PRG_AW (17) | Physical PRG ROM byte address |
| prg_rom_sel | output | 1 | CPU access falls in ROM space |
| prg_ram_sel | output | 1 | CPU access falls in RAM space |
| prg_ram_wen | output | 1 | PRG RAM write permitted |
| chr_addr | output | CHR_AW (17) | Physical CHR byte address |
| mirror | output | 2 | Nametable mirroring code |

## Verification
The bench goes after the PRG bank bit 0 in the 32 KB layout (a design that used it would shift the whole window by 16 KB), the pinned last bank (a design using 15 or the selected bank would read the wrong code at the reset vector), and the 8 KB CHR layout (keeping bit 0 of CHR bank 0 would mis-order the two halves). It also rewrites only the control register and expects the translation to move at once, which catches a design that latches offsets only when a bank register is written. Bank values beyond the ROM size catch a design that does not wrap, and the RAM gate bit is toggled to show it blocks writes without disturbing the ROM bank.

// File: rtl/bank_xlate_pkg.sv
package bank_xlate_pkg;

    typedef enum logic [1:0] {
        MIR_ONE_LO = 2'd0,
        MIR_ONE_HI = 2'd1,
        MIR_VERT   = 2'd2,
        MIR_HORZ   = 2'd3
    } mirror_e;

    typedef enum logic [1:0] {
        PRG_WHOLE32,
        PRG_PIN_FIRST,
        PRG_PIN_LAST
    } prg_mode_e;

    typedef enum logic {
        CHR_PAIR8K  = 1'b0,
        CHR_SPLIT4K = 1'b1
    } chr_mode_e;

    typedef struct packed {
        mirror_e   mir;
        prg_mode_e prg;
        chr_mode_e chr;
    } layout_t;

    // Control layout: [4] CHR layout, [3:2] PRG layout, [1:0] mirroring
    function automatic layout_t decode_ctl(input logic [4:0] c);
        layout_t l;
        l.mir = mirror_e'(c[1:0]);
        l.chr = chr_mode_e'(c[4]);
        unique case (c[3:2])
            2'b10:   l.prg = PRG_PIN_FIRST;
            2'b11:   l.prg = PRG_PIN_LAST;
            default: l.prg = PRG_WHOLE32;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/bank_cfg_regs.sv
module bank_cfg_regs #(
    parameter int REG_W  = 5,
    parameter int N_REGS = 4,
    parameter logic [N_REGS*REG_W-1:0] RST_VALS = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_REGS-1:0]      ld,
    input  logic [REG_W-1:0]       wdata,
    output logic [REG_W-1:0]       q [N_REGS]
);

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        logic [REG_W-1:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r <= RST_VALS[g*REG_W +: REG_W];
            else if (ld[g])
                r <= wdata;
        end
        assign q[g] = r;
    end

endmodule

// File: rtl/bank_prg_window.sv
module bank_prg_window
    import bank_xlate_pkg::*;
#(
    parameter int PRG_BANKS = 8
) (
    input  prg_mode_e                  mode,
    input  logic [3:0]                 bank_sel,
    input  logic [14:0]                cpu_addr,
    output logic [$clog2(PRG_BANKS)+13:0] rom_addr
);

    localparam int PB   = $clog2(PRG_BANKS);
    localparam int BW   = ((PB > 4) ? PB : 4) + 1;
    localparam logic [BW-1:0] LAST = BW'(PRG_BANKS - 1);
    localparam logic [BW-1:0] SIZE = BW'(PRG_BANKS);

    logic          win;
    logic [BW-1:0] sel;
    logic [BW-1:0] bank;
    logic [PB-1:0] bank_mod;

    assign win = cpu_addr[14];
    assign sel = BW'(bank_sel);

    always_comb begin
        unique case (mode)
            PRG_WHOLE32:   bank = {sel[BW-1:1], win};
            PRG_PIN_FIRST: bank = win ? sel : '0;
            PRG_PIN_LAST:  bank = win ? LAST : sel;
            default:       bank = '0;
        endcase
    end

    assign bank_mod = PB'(bank % SIZE);
    assign rom_addr = {bank_mod, cpu_addr[13:0]};

endmodule

// File: rtl/bank_chr_window.sv
module bank_chr_window
    import bank_xlate_pkg::*;
#(
    parameter int CHR_BANKS = 32
) (
    input  chr_mode_e                      mode,
    input  logic [4:0]                     lo_sel,
    input  logic [4:0]                     hi_sel,
    input  logic [12:0]                    ppu_addr,
    output logic [$clog2(CHR_BANKS)+11:0]  chr_addr
);

    localparam int CB = $clog2(CHR_BANKS);
    localparam int CW = ((CB > 5) ? CB : 5) + 1;
    localparam logic [CW-1:0] SIZE = CW'(CHR_BANKS);

    logic          win;
    logic [CW-1:0] bank;
    logic [CB-1:0] bank_mod;

    assign win = ppu_addr[12];

    always_comb begin
        unique case (mode)
            CHR_PAIR8K:  bank = CW'({lo_sel[4:1], win});
            CHR_SPLIT4K: bank = CW'(win ? hi_sel : lo_sel);
            default:     bank = '0;
        endcase
    end

    assign bank_mod = CB'(bank % SIZE);
    assign chr_addr = {bank_mod, ppu_addr[11:0]};

endmodule

// File: rtl/bank_xlate_top.sv
module bank_xlate_top
    import bank_xlate_pkg::*;
#(
    parameter int PRG_BANKS = 8,
    parameter int CHR_BANKS = 32,
    localparam int PRG_AW = $clog2(PRG_BANKS) + 14,
    localparam int CHR_AW = $clog2(CHR_BANKS) + 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_ld,
    input  logic              chr0_ld,
    input  logic              chr1_ld,
    input  logic              prg_ld,
    input  logic [4:0]        reg_wdata,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_wr,
    input  logic [12:0]       ppu_addr,
    output logic [PRG_AW-1:0] prg_rom_addr,
    output logic              prg_rom_sel,
    output logic              prg_ram_sel,
    output logic              prg_ram_wen,
    output logic [CHR_AW-1:0] chr_addr,
    output logic [1:0]        mirror
);

    localparam int N_REGS = 4;
    localparam logic [4:0] CTL_RESET = 5'h0F;
    localparam logic [N_REGS*5-1:0] RST_VALS = {5'h00, 5'h00, 5'h00, CTL_RESET};

    logic [4:0] regs_q [N_REGS];
    logic [4:0] ctl_q, chr0_q, chr1_q, prg_q;
    layout_t    lay;

    bank_cfg_regs #(
        .REG_W    (5),
        .N_REGS   (N_REGS),
        .RST_VALS (RST_VALS)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    ({prg_ld, chr1_ld, chr0_ld, ctl_ld}),
        .wdata (reg_wdata),
        .q     (regs_q)
    );

    assign ctl_q  = regs_q[0];
    assign chr0_q = regs_q[1];
    assign chr1_q = regs_q[2];
    assign prg_q  = regs_q[3];

    assign lay = decode_ctl(ctl_q);

    bank_prg_window #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .mode     (lay.prg),
        .bank_sel (prg_q[3:0]),
        .cpu_addr (cpu_addr[14:0]),
        .rom_addr (prg_rom_addr)
    );

    bank_chr_window #(.CHR_BANKS(CHR_BANKS)) u_chr (
        .mode     (lay.chr),
        .lo_sel   (chr0_q),
        .hi_sel   (chr1_q),
        .ppu_addr (ppu_addr),
        .chr_addr (chr_addr)
    );

    assign prg_rom_sel = cpu_addr[15];
    assign prg_ram_sel = (cpu_addr[15:13] == 3'b011);
    assign prg_ram_wen = prg_ram_sel && cpu_wr && !prg_q[4];
    assign mirror      = lay.mir;

endmodule

// File: rtl/bank_xlate_chk.sv
module bank_xlate_chk #(
    parameter int PRG_BANKS = 8,
    parameter int CHR_BANKS = 32,
    localparam int PB     = $clog2(PRG_BANKS),
    localparam int PRG_AW = PB + 14,
    localparam int CHR_AW = $clog2(CHR_BANKS) + 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_ld,
    input logic [4:0]        reg_wdata,
    input logic [4:0]        ctl_q,
    input logic [15:0]       cpu_addr,
    input logic              cpu_wr,
    input logic [12:0]       ppu_addr,
    input logic [PRG_AW-1:0] prg_rom_addr,
    input logic              prg_rom_sel,
    input logic              prg_ram_sel,
    input logic              prg_ram_wen,
    input logic [CHR_AW-1:0] chr_addr,
    input logic [1:0]        mirror
);

    // R9
    sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prg_ram_sel && prg_rom_sel));

    // R8
    wen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prg_ram_wen |-> (prg_ram_sel && cpu_wr));

    // R2
    mirror_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_ld |=> (mirror == $past(reg_wdata[1:0])));

    // R10
    mirror_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_ld |=> $stable(mirror));

    // R7
    pin_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prg_rom_sel && cpu_addr[14] && ctl_q[3:2] == 2'b11)
        |-> (prg_rom_addr[PRG_AW-1:14] == PB'(PRG_BANKS - 1)));

    // R6
    pin_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prg_rom_sel && !cpu_addr[14] && ctl_q[3:2] == 2'b10)
        |-> (prg_rom_addr[PRG_AW-1:14] == '0));

    // R3
    chr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[4] |-> (chr_addr[12] == ppu_addr[12]));

    // R11
    prg_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prg_rom_addr[13:0] == cpu_addr[13:0]);

    // R11
    chr_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chr_addr[11:0] == ppu_addr[11:0]);

endmodule

bind bank_xlate_top bank_xlate_chk #(
    .PRG_BANKS (PRG_BANKS),
    .CHR_BANKS (CHR_BANKS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_ld       (ctl_ld),
    .reg_wdata    (reg_wdata),
    .ctl_q        (ctl_q),
    .cpu_addr     (cpu_addr),
    .cpu_wr       (cpu_wr),
    .ppu_addr     (ppu_addr),
    .prg_rom_addr (prg_rom_addr),
    .prg_rom_sel  (prg_rom_sel),
    .prg_ram_sel  (prg_ram_sel),
    .prg_ram_wen  (prg_ram_wen),
    .chr_addr     (chr_addr),
    .mirror       (mirror)
);

// File: tb/bank_xlate_top_test.sv
`timescale 1ns/1ps
module bank_xlate_top_test;

    localparam int PRG_BANKS = 8;
    localparam int CHR_BANKS = 32;
    localparam int PRG_AW = 17;
    localparam int CHR_AW = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctl_ld = 1'b0, chr0_ld = 1'b0, chr1_ld = 1'b0, prg_ld = 1'b0;
    logic [4:0]        reg_wdata = '0;
    logic [15:0]       cpu_addr = '0;
    logic              cpu_wr = 1'b0;
    logic [12:0]       ppu_addr = '0;
    logic [PRG_AW-1:0] prg_rom_addr;
    logic              prg_rom_sel, prg_ram_sel, prg_ram_wen;
    logic [CHR_AW-1:0] chr_addr;
    logic [1:0]        mirror;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [4:0] m_ctl, m_chr0, m_chr1, m_prg;

    always #2.5 clk = ~clk;

    bank_xlate_top #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) uut (
        .clk(clk), .rst_n(rst_n),
        .ctl_ld(ctl_ld), .chr0_ld(chr0_ld), .chr1_ld(chr1_ld), .prg_ld(prg_ld),
        .reg_wdata(reg_wdata), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .ppu_addr(ppu_addr), .prg_rom_addr(prg_rom_addr),
        .prg_rom_sel(prg_rom_sel), .prg_ram_sel(prg_ram_sel),
        .prg_ram_wen(prg_ram_wen), .chr_addr(chr_addr), .mirror(mirror)
    );

    function automatic logic [31:0] exp_prg(input logic [15:0] a);
        int w = int'(a[14]);
        int b4 = int'(m_prg[3:0]);
        int bank;
        case (m_ctl[3:2])
            2'd2:    bank = w ? b4 : 0;
            2'd3:    bank = w ? PRG_BANKS - 1 : b4;
            default: bank = (b4 / 2) * 2 + w;
        endcase
        bank = bank % PRG_BANKS;
        return 32'(bank * 16384 + int'(a[13:0]));
    endfunction

    function automatic logic [31:0] exp_chr(input logic [12:0] a);
        int w = int'(a[12]);
        int bank;
        if (!m_ctl[4]) bank = (int'(m_chr0) / 2) * 2 + w;
        else           bank = w ? int'(m_chr1) : int'(m_chr0);
        bank = bank % CHR_BANKS;
        return 32'(bank * 4096 + int'(a[11:0]));
    endfunction

    function automatic string prg_tag();
        case (m_ctl[3:2])
            2'd2:    return "R6";
            2'd3:    return "R7";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [4:0] v);
        @(negedge clk);
        reg_wdata = v;
        ctl_ld  = (idx == 0);
        chr0_ld = (idx == 1);
        chr1_ld = (idx == 2);
        prg_ld  = (idx == 3);
        @(negedge clk);
        {ctl_ld, chr0_ld, chr1_ld, prg_ld} = '0;
        case (idx)
            0: m_ctl  = v;
            1: m_chr0 = v;
            2: m_chr1 = v;
            default: m_prg = v;
        endcase
    endtask

    task automatic probe(input logic [15:0] ca, input logic wr, input logic [12:0] pa);
        logic in_ram, in_rom;
        cpu_addr = ca;
        cpu_wr = wr;
        ppu_addr = pa;
        #1;
        in_ram = (ca >= 16'h6000 && ca <= 16'h7FFF);
        in_rom = (ca >= 16'h8000);
        check("R9 ram_sel", 32'(prg_ram_sel), 32'(in_ram));
        check("R9 rom_sel", 32'(prg_rom_sel), 32'(in_rom));
        check("R8 ram_wen", 32'(prg_ram_wen), 32'(in_ram && wr && !m_prg[4]));
        check("R2 mirror", 32'(mirror), 32'(m_ctl[1:0]));
        check(m_ctl[4] ? "R4 chr_addr" : "R3 chr_addr", 32'(chr_addr), exp_chr(pa));
        if (in_rom) check({prg_tag(), " prg_addr"}, 32'(prg_rom_addr), exp_prg(ca));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0B1C));
        m_ctl = 5'h0F; m_chr0 = '0; m_chr1 = '0; m_prg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        probe(16'hC123, 1'b0, 13'h1ABC);
        check("R1 mirror", 32'(mirror), 32'd3);
        check("R1 upper window", 32'(prg_rom_addr), 32'h1C123);
        probe(16'h8000, 1'b0, 13'h0005);
        check("R1 lower window", 32'(prg_rom_addr), 32'h00000);

        // R5: bit 0 ignored in 32 KB layout
        load(0, 5'h10);
        load(3, 5'h05);
        probe(16'h8010, 1'b0, 13'h0000);
        check("R5 bit0 ignored lo", 32'(prg_rom_addr), 32'h10010);
        probe(16'hC010, 1'b0, 13'h0000);
        check("R5 bit0 ignored hi", 32'(prg_rom_addr), 32'h14010);

        // R10: mode change with no bank rewrite
        load(0, 5'h18);
        probe(16'h8010, 1'b0, 13'h0000);
        check("R10 pin first lo", 32'(prg_rom_addr), 32'h00010);
        probe(16'hC010, 1'b0, 13'h0000);
        check("R10 pin first hi", 32'(prg_rom_addr), 32'h14010);

        // R11: wrap of bank 12 to 4 in 8-bank ROM, pinned last
        load(0, 5'h1C);
        load(3, 5'h0C);
        probe(16'h9234, 1'b0, 13'h0000);
        check("R11 prg wrap", 32'(prg_rom_addr), 32'h11234);
        probe(16'hFFFC, 1'b0, 13'h0000);
        check("R7 last bank", 32'(prg_rom_addr), 32'h1FFFC);

        // R8: gate bit blocks writes, ROM bank unchanged
        load(3, 5'h1C);
        probe(16'h6ABC, 1'b1, 13'h0000);
        check("R8 gated wen", 32'(prg_ram_wen), 32'd0);
        probe(16'h9234, 1'b0, 13'h0000);
        check("R8 rom unaffected", 32'(prg_rom_addr), 32'h11234);
        load(3, 5'h0C);
        probe(16'h7FFF, 1'b1, 13'h0000);
        check("R8 open wen", 32'(prg_ram_wen), 32'd1);

        // R3 / R4: CHR layouts
        load(1, 5'h07);
        load(2, 5'h13);
        load(0, 5'h0E);
        probe(16'h0000, 1'b0, 13'h0123);
        check("R3 chr lo", 32'(chr_addr), 32'h06123);
        probe(16'h0000, 1'b0, 13'h1123);
        check("R3 chr hi", 32'(chr_addr), 32'h07123);
        load(0, 5'h1E);
        probe(16'h0000, 1'b0, 13'h0123);
        check("R4 chr lo", 32'(chr_addr), 32'h07123);
        probe(16'h0000, 1'b0, 13'h1123);
        check("R4 chr hi", 32'(chr_addr), 32'h13123);

        // R2: every mirroring code
        for (int m = 0; m < 4; m++) begin
            load(0, 5'(m) | 5'h0C);
            check("R2 mirror code", 32'(mirror), 32'(m));
        end

        // Constrained random mix
        for (int it = 0; it < 400; it++) begin
            int reg_idx = int'($urandom % 5);
            int region = int'($urandom % 3);
            logic [15:0] ca;
            if (reg_idx < 4) load(reg_idx, 5'($urandom));
            case (region)
                0:       ca = 16'h6000 | 16'($urandom % 16'h2000);
                1:       ca = 16'h8000 | 16'($urandom % 16'h8000);
                default: ca = 16'($urandom % 16'h6000);
            endcase
            probe(ca, 1'($urandom), 13'($urandom));
            @(negedge clk);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule